// File: doc/BRIEF.md
# Single-Precision Floating-Point Add/Subtract Unit

This block takes two 32-bit single-precision operands and either adds them or subtracts the second from the first. It returns a correctly rounded single-precision word. The work is spread over four register stages, and a new operation can start on every clock.

- **Stage 1** unpacks both operands and orders them by magnitude.
- **Stage 2** aligns the smaller significand and forms the raw sum or difference.
- **Stage 3** normalises in whichever direction the raw result needs.
- **Stage 4** rounds to nearest-even and resolves the special encodings.

A valid strobe travels alongside each operation, so a result can be matched to its request without any backpressure.

Subnormal operands are accepted and subnormal results are produced by default. A parameter instead replaces any result below the smallest normal magnitude with a signed zero. NaN outputs always use one canonical quiet pattern.

Top module: `fp32_addsub`

## Requirements
- R1: A word is read as sign in bit 31, biased exponent (bias 127) in bits 30:23 and fraction in bits 22:0, with a hidden 1 when the exponent is non-zero. Adding two normal operands gives the correctly rounded sum, whichever operand holds the larger magnitude (3.875 + 1.625: 0x40780000 + 0x3FD00000 = 0x40B00000).
- R2: With `sub_sel` high the sign of `op_b` is inverted before the operation. The result takes the sign of the operand with the larger magnitude (0x3FD00000 − 0x40780000 = 0xC0100000).
- R3: When the significand sum reaches 2.0 or more, the result is shifted right by one place and the exponent is raised by one.
- R4: After cancellation the significand is shifted left until its leading one reaches the hidden position, and the exponent is reduced by the same amount (1.0 − 0.75 = 0x3E800000).
- R5: Rounding is to nearest with ties to even, using the bits shifted out during alignment. A round-up that carries out of the significand renormalises the result (0x3FFFFFFF + 0x33800000 = 0x40000000).
- R6: An exact zero from operands of opposite effective sign is +0 (0x00000000). Adding two zeros of the same sign keeps that sign (−0 + −0 = 0x80000000).
- R7: A NaN operand (exponent 0xFF, fraction non-zero), or infinities of opposite effective sign, gives the quiet NaN 0x7FC00000. No other NaN pattern ever leaves the block.
- R8: An infinity (exponent 0xFF, fraction zero) combined with a finite operand, or with an infinity of the same effective sign, returns that infinity with its effective sign.
- R9: A finite result whose exponent would reach 0xFF, before or after rounding, returns infinity with the result's sign.
- R10: Exponent 0 with a non-zero fraction is a subnormal operand. It has no hidden bit and is weighted as exponent 1. A result below the smallest normal magnitude leaves with exponent field 0 and its exact subnormal fraction.
- R11: With `FLUSH_SUBNORM` set to 1, any finite result with exponent field 0 is returned as a zero carrying the result's sign.
- R12: `out_valid` and its `result` appear exactly 4 clock edges after the edge that samples `in_valid` high. Back-to-back requests produce back-to-back results in the same order.
- R13: While `rst_n` is low at a clock edge, `out_valid` goes low at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands and operation are presented this cycle |
| sub_sel | input | 1 | 1 = subtract `op_b` from `op_a`, 0 = add |
| op_a | input | 32 | First single-precision operand |
| op_b | input | 32 | Second single-precision operand |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 32 | Rounded single-precision result |

## Verification
The operand patterns are chosen so that each one drives a different path through the datapath:

- **Carry case.** Operands with nearby exponents and a large sum exercise the right normalising shift.
- **Cancellation case.** Near-equal magnitudes of opposite sign exercise the leading-one search and the left shift.
- **Order check.** Swapped operand orders show that the magnitude swap makes the result independent of which port holds the larger value.
- **Rounding cases.** Operands placed exactly half an ulp, just above half, and far below half separate round-down, round-up, tie-to-even and the carry-out renormalisation. One case also shows the sticky bit's effect after a very large exponent gap.
- **Special and edge encodings.** Zeros, infinities, NaNs and subnormals are applied to both instances; one instance flushes subnormal results and the other does not. These cases show which special rule wins.
- **Streamed requests.** A burst of back-to-back requests shows the fixed latency and the order of results.

// File: rtl/fpa_pkg.sv
// Package: fpa_pkg
// Shared widths and stage-boundary records for the single-precision
// add/subtract pipeline. Assumes the 1/8/23 word layout.
package fpa_pkg;

    localparam int EXP_W  = 8;                 // biased exponent width
    localparam int MAN_W  = 23;                // stored fraction width
    localparam int WORD_W = 1 + EXP_W + MAN_W; // full word
    localparam int SIG_W  = MAN_W + 1;         // fraction plus hidden bit
    localparam int GRS_W  = 3;                 // guard, round, sticky
    localparam int ALN_W  = SIG_W + GRS_W;     // aligned significand
    localparam int SUM_W  = ALN_W + 1;         // with carry-out
    localparam int EXPX_W = EXP_W + 1;         // exponent with overflow room
    localparam int LZ_W   = $clog2(ALN_W + 1); // leading-zero count

    localparam logic [EXP_W-1:0]  EXP_ONES = '1;
    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } fp_word_t;

    typedef struct packed {
        logic nan;
        logic inf;
        logic inf_sign;
    } spec_t;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic             eff_sub;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig_big;
        logic [SIG_W-1:0] sig_small;
        logic [EXP_W-1:0] diff;
        spec_t            spec;
    } stg1_t;

    typedef struct packed {
        logic             valid;
        logic             sign;
        logic             eff_sub;
        logic [EXP_W-1:0] exp;
        logic [SUM_W-1:0] sum;
        spec_t            spec;
    } stg2_t;

    typedef struct packed {
        logic              valid;
        logic              sign;
        logic              eff_sub;
        logic              zero;
        logic [EXPX_W-1:0] exp;
        logic [ALN_W-1:0]  man;
        spec_t             spec;
    } stg3_t;

endpackage

// File: rtl/fpa_unpack_swap.sv
// Module: fpa_unpack_swap
// Stage 1. Decodes both operands, applies the subtract control to the
// second sign, classifies NaN/infinity, and orders the pair by magnitude
// so the larger one always takes the unshifted path. Subnormals get no
// hidden bit and an effective exponent of 1. Registered output.
module fpa_unpack_swap
    import fpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_sel,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output stg1_t             s1_q
);

    fp_word_t         wa, wb;
    logic             sb;
    logic             a_den, b_den;
    logic [EXP_W-1:0] ea, eb;
    logic [SIG_W-1:0] siga, sigb;
    logic             a_nan, b_nan, a_inf, b_inf;
    logic             a_ge;
    stg1_t            s1_d;

    assign wa = op_a;
    assign wb = op_b;

    // Decode each operand and compare magnitudes.
    always_comb begin
        sb    = wb.sign ^ sub_sel;
        a_den = (wa.exp == '0);
        b_den = (wb.exp == '0);
        ea    = a_den ? EXP_W'(1) : wa.exp;
        eb    = b_den ? EXP_W'(1) : wb.exp;
        siga  = {~a_den, wa.man};
        sigb  = {~b_den, wb.man};
        a_nan = (wa.exp == EXP_ONES) && (wa.man != '0);
        b_nan = (wb.exp == EXP_ONES) && (wb.man != '0);
        a_inf = (wa.exp == EXP_ONES) && (wa.man == '0);
        b_inf = (wb.exp == EXP_ONES) && (wb.man == '0);
        a_ge  = {ea, siga} >= {eb, sigb};
    end

    // Swap the pair and gather the stage-1 record.
    always_comb begin
        s1_d.valid     = in_valid;
        s1_d.eff_sub   = wa.sign ^ sb;
        s1_d.sign      = a_ge ? wa.sign : sb;
        s1_d.exp       = a_ge ? ea : eb;
        s1_d.sig_big   = a_ge ? siga : sigb;
        s1_d.sig_small = a_ge ? sigb : siga;
        s1_d.diff      = a_ge ? (ea - eb) : (eb - ea);
        s1_d.spec.nan  = a_nan | b_nan | (a_inf & b_inf & (wa.sign != sb));
        s1_d.spec.inf  = a_inf | b_inf;
        s1_d.spec.inf_sign = a_inf ? wa.sign : sb;
    end

    // Stage-1 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

endmodule

// File: rtl/fpa_align_add.sv
// Module: fpa_align_add
// Stage 2. Shifts the smaller significand right by the exponent gap,
// folding every bit shifted out below the round bit into a sticky bit,
// then adds or subtracts. Assumes stage 1 put the larger magnitude on
// sig_big, so the difference is never negative. Registered output.
module fpa_align_add
    import fpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stg1_t s1,
    output stg2_t s2_q
);

    localparam int WIDE_W = SIG_W + ALN_W - 1;

    logic [WIDE_W-1:0] wide, shifted;
    logic [ALN_W-1:0]  big_al, small_al;
    stg2_t             s2_d;

    // Align the smaller operand with guard, round and sticky kept.
    always_comb begin
        wide     = {s1.sig_small, {(ALN_W-1){1'b0}}};
        shifted  = wide >> s1.diff;
        small_al = {shifted[WIDE_W-1 -: ALN_W-1], |shifted[WIDE_W-ALN_W:0]};
        big_al   = {s1.sig_big, {GRS_W{1'b0}}};
    end

    // Add or subtract the aligned significands.
    always_comb begin
        s2_d.valid   = s1.valid;
        s2_d.sign    = s1.sign;
        s2_d.eff_sub = s1.eff_sub;
        s2_d.exp     = s1.exp;
        s2_d.spec    = s1.spec;
        s2_d.sum     = s1.eff_sub ? ({1'b0, big_al} - {1'b0, small_al})
                                  : ({1'b0, big_al} + {1'b0, small_al});
    end

    // Stage-2 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

endmodule

// File: rtl/fpa_normalize.sv
// Module: fpa_normalize
// Stage 3. On carry-out, shifts right one place (keeping the sticky) and
// bumps the exponent. Otherwise a leading-one search sets a left shift,
// limited so the exponent never drops below 1; a result that then still
// lacks its hidden bit is subnormal. Registered output.
module fpa_normalize
    import fpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  stg2_t s2,
    output stg3_t s3_q
);

    logic [ALN_W-1:0]  body;
    logic [LZ_W-1:0]   lz;
    logic [EXPX_W-1:0] room, lz_x, sh;
    stg3_t             s3_d;

    assign body = s2.sum[ALN_W-1:0];

    // Priority encoder: count leading zeros of the uncarried body.
    always_comb begin
        lz = LZ_W'(ALN_W);
        for (int i = 0; i < ALN_W; i++) begin
            if (body[i]) lz = LZ_W'(ALN_W - 1 - i);
        end
    end

    // Limit the left shift to the exponent headroom above 1.
    always_comb begin
        room = {1'b0, s2.exp} - EXPX_W'(1);
        lz_x = EXPX_W'(lz);
        sh   = (lz_x > room) ? room : lz_x;
    end

    // Pick the normalising direction and build the stage-3 record.
    always_comb begin
        s3_d.valid   = s2.valid;
        s3_d.sign    = s2.sign;
        s3_d.eff_sub = s2.eff_sub;
        s3_d.spec    = s2.spec;
        s3_d.zero    = (s2.sum == '0);
        if (s2.sum[SUM_W-1]) begin
            s3_d.man = {s2.sum[SUM_W-1:2], s2.sum[1] | s2.sum[0]};
            s3_d.exp = {1'b0, s2.exp} + EXPX_W'(1);
        end else begin
            s3_d.man = body << sh;
            s3_d.exp = {1'b0, s2.exp} - sh;
        end
    end

    // Stage-3 pipeline register.
    always_ff @(posedge clk) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

endmodule

// File: rtl/fpa_round_pack.sv
// Module: fpa_round_pack
// Stage 4. Rounds to nearest-even, renormalises a rounding carry, and
// packs the word. Special cases are resolved in priority order: NaN,
// infinity, exact zero, overflow, optional flush of subnormals.
// Assumes the exponent from stage 3 is at least 1. Registered output.
module fpa_round_pack
    import fpa_pkg::*;
#(
    parameter bit FLUSH_SUBNORM = 1'b0
)(
    input  logic              clk,
    input  logic              rst_n,
    input  stg3_t             s3,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    logic              lsb, grd, rnd_b, stk, inc;
    logic [SIG_W:0]    rnd;
    logic [SIG_W-1:0]  sig;
    logic [EXPX_W-1:0] exp_f;
    logic [EXP_W-1:0]  field_exp;
    logic [WORD_W-1:0] word_d;

    // Round to nearest, ties to even, and renormalise a carry.
    always_comb begin
        lsb   = s3.man[GRS_W];
        grd   = s3.man[GRS_W-1];
        rnd_b = s3.man[GRS_W-2];
        stk   = |s3.man[GRS_W-3:0];
        inc   = grd & (rnd_b | stk | lsb);
        rnd   = {1'b0, s3.man[ALN_W-1:GRS_W]} + {{SIG_W{1'b0}}, inc};
        sig   = rnd[SIG_W] ? rnd[SIG_W:1] : rnd[SIG_W-1:0];
        exp_f = s3.exp + EXPX_W'(rnd[SIG_W]);
        field_exp = sig[SIG_W-1] ? exp_f[EXP_W-1:0] : '0;
    end

    // Resolve specials and pack the output word.
    always_comb begin
        if (s3.spec.nan)
            word_d = QNAN_WORD;
        else if (s3.spec.inf)
            word_d = {s3.spec.inf_sign, EXP_ONES, {MAN_W{1'b0}}};
        else if (s3.zero)
            word_d = {s3.sign & ~s3.eff_sub, {(WORD_W-1){1'b0}}};
        else if (exp_f >= {1'b0, EXP_ONES})
            word_d = {s3.sign, EXP_ONES, {MAN_W{1'b0}}};
        else if (FLUSH_SUBNORM && !sig[SIG_W-1])
            word_d = {s3.sign, {(WORD_W-1){1'b0}}};
        else
            word_d = {s3.sign, field_exp, sig[MAN_W-1:0]};
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s3.valid;
            result    <= word_d;
        end
    end

endmodule

// File: rtl/fp32_addsub.sv
// Module: fp32_addsub
// Four-stage single-precision add/subtract pipeline: order, align and
// add, normalise, round and pack. Accepts one operation per clock with
// no backpressure; results leave exactly four edges after acceptance.
module fp32_addsub
    import fpa_pkg::*;
#(
    parameter bit FLUSH_SUBNORM = 1'b0
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        sub_sel,
    input  logic [31:0] op_a,
    input  logic [31:0] op_b,
    output logic        out_valid,
    output logic [31:0] result
);

    stg1_t s1;
    stg2_t s2;
    stg3_t s3;

    fpa_unpack_swap u_s1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .s1_q(s1)
    );

    fpa_align_add u_s2 (
        .clk(clk), .rst_n(rst_n), .s1(s1), .s2_q(s2)
    );

    fpa_normalize u_s3 (
        .clk(clk), .rst_n(rst_n), .s2(s2), .s3_q(s3)
    );

    fpa_round_pack #(.FLUSH_SUBNORM(FLUSH_SUBNORM)) u_s4 (
        .clk(clk), .rst_n(rst_n), .s3(s3),
        .out_valid(out_valid), .result(result)
    );

endmodule

// File: rtl/fp32_addsub_chk.sv
// Module: fp32_addsub_chk
// Port-level temporal checks for fp32_addsub, attached by bind.
module fp32_addsub_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        sub_sel,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic        out_valid,
    input logic [31:0] result
);

    logic [2:0] run_cnt;

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (run_cnt != 3'd4) run_cnt <= run_cnt + 3'd1;
    end

    // R13
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !out_valid);

    // R12
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R7
    canon_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && result[30:23] == 8'hFF && result[22:0] != '0)
        |-> (result == 32'h7FC0_0000));

    // R7
    nan_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a[30:23] == 8'hFF && op_a[22:0] != '0)
        |-> ##4 (out_valid && result == 32'h7FC0_0000));

    // R8
    inf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_a[30:0] == 31'h7F80_0000 && op_b[30:23] != 8'hFF)
        |-> ##4 (result == {op_a[31], 31'h7F80_0000}) && !$isunknown(sub_sel));

endmodule

bind fp32_addsub fp32_addsub_chk u_chk (.*);

// File: tb/sim_fp32_addsub.sv
`timescale 1ns/1ps
module sim_fp32_addsub;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        sub_sel = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid, out_valid_f;
    logic [31:0] result, result_f;
    int          total = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    fp32_addsub #(.FLUSH_SUBNORM(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .result(result)
    );

    fp32_addsub #(.FLUSH_SUBNORM(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_sel(sub_sel),
        .op_a(op_a), .op_b(op_b), .out_valid(out_valid_f), .result(result_f)
    );

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Issue one operation and wait until its result is due.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                          input logic s, output logic [31:0] r,
                          output logic [31:0] rf, output logic v);
        @(negedge clk);
        op_a = a; op_b = b; sub_sel = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        r = result; rf = result_f; v = out_valid;
    endtask

    task automatic vec(input string req, input logic [31:0] a,
                       input logic [31:0] b, input logic s,
                       input logic [31:0] exp);
        logic [31:0] r, rf;
        logic v;
        run_op(a, b, s, r, rf, v);
        check(req, {31'b0, v}, 32'd1);
        check(req, r, exp);
    endtask

    task automatic vec_flush(input string req, input logic [31:0] a,
                             input logic [31:0] b, input logic s,
                             input logic [31:0] exp);
        logic [31:0] r, rf;
        logic v;
        run_op(a, b, s, r, rf, v);
        check(req, rf, exp);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R13 reset", {31'b0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R13 after", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_add;
        vec("R1 add", 32'h4078_0000, 32'h3FD0_0000, 1'b0, 32'h40B0_0000);
        vec("R1 swapped", 32'h3FD0_0000, 32'h4078_0000, 1'b0, 32'h40B0_0000);
        vec("R1 1+2", 32'h3F80_0000, 32'h4000_0000, 1'b0, 32'h4040_0000);
        vec("R3 carry", 32'h3FC0_0000, 32'h3FC0_0000, 1'b0, 32'h4040_0000);
    endtask

    task automatic t_sub;
        vec("R2 sub", 32'h4078_0000, 32'h3FD0_0000, 1'b1, 32'h4010_0000);
        vec("R2 neg", 32'h3FD0_0000, 32'h4078_0000, 1'b1, 32'hC010_0000);
        vec("R2 minus neg", 32'h3F80_0000, 32'hBF80_0000, 1'b1, 32'h4000_0000);
        vec("R4 cancel", 32'h3F80_0000, 32'h3F40_0000, 1'b1, 32'h3E80_0000);
    endtask

    task automatic t_zero;
        vec("R6 x-x", 32'h3F80_0000, 32'h3F80_0000, 1'b1, 32'h0000_0000);
        vec("R6 -x+x", 32'hBF80_0000, 32'h3F80_0000, 1'b0, 32'h0000_0000);
        vec("R6 -0+-0", 32'h8000_0000, 32'h8000_0000, 1'b0, 32'h8000_0000);
        vec("R6 -0--0", 32'h8000_0000, 32'h8000_0000, 1'b1, 32'h0000_0000);
    endtask

    task automatic t_round;
        vec("R5 tie even", 32'h3F80_0000, 32'h3380_0000, 1'b0, 32'h3F80_0000);
        vec("R5 tie odd", 32'h3F80_0001, 32'h3380_0000, 1'b0, 32'h3F80_0002);
        vec("R5 above", 32'h3F80_0000, 32'h33C0_0000, 1'b0, 32'h3F80_0001);
        vec("R5 carry", 32'h3FFF_FFFF, 32'h3380_0000, 1'b0, 32'h4000_0000);
        vec("R5 sticky", 32'h3F80_0000, 32'h0000_0001, 1'b1, 32'h3F80_0000);
    endtask

    task automatic t_special;
        vec("R7 nan a", 32'h7FC0_0001, 32'h3F80_0000, 1'b0, 32'h7FC0_0000);
        vec("R7 nan b", 32'h3F80_0000, 32'hFF80_0001, 1'b0, 32'h7FC0_0000);
        vec("R7 inf-inf", 32'h7F80_0000, 32'hFF80_0000, 1'b0, 32'h7FC0_0000);
        vec("R7 inf sub", 32'h7F80_0000, 32'h7F80_0000, 1'b1, 32'h7FC0_0000);
        vec("R8 inf+1", 32'h7F80_0000, 32'h3F80_0000, 1'b0, 32'h7F80_0000);
        vec("R8 1-inf", 32'h3F80_0000, 32'h7F80_0000, 1'b1, 32'hFF80_0000);
        vec("R8 -inf+max", 32'hFF80_0000, 32'h7F7F_FFFF, 1'b0, 32'hFF80_0000);
        vec("R8 inf+inf", 32'h7F80_0000, 32'h7F80_0000, 1'b0, 32'h7F80_0000);
    endtask

    task automatic t_overflow;
        vec("R9 max+max", 32'h7F7F_FFFF, 32'h7F7F_FFFF, 1'b0, 32'h7F80_0000);
        vec("R9 neg", 32'hFF7F_FFFF, 32'hFF7F_FFFF, 1'b0, 32'hFF80_0000);
        vec("R9 sub", 32'h7F7F_FFFF, 32'hFF7F_FFFF, 1'b1, 32'h7F80_0000);
        vec("R9 round", 32'h7F7F_FFFF, 32'h7300_0000, 1'b0, 32'h7F80_0000);
    endtask

    task automatic t_subnormal;
        vec("R10 tiny", 32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0000_0002);
        vec("R10 to norm", 32'h0040_0000, 32'h0040_0000, 1'b0, 32'h0080_0000);
        vec("R10 to sub", 32'h0080_0000, 32'h0000_0001, 1'b1, 32'h007F_FFFF);
        vec("R10 sub-sub", 32'h0000_0003, 32'h0000_0001, 1'b1, 32'h0000_0002);
        vec_flush("R11 flush", 32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0000_0000);
        vec_flush("R11 flush2", 32'h0080_0000, 32'h0000_0001, 1'b1, 32'h0000_0000);
        vec_flush("R11 keep", 32'h0040_0000, 32'h0040_0000, 1'b0, 32'h0080_0000);
        vec_flush("R11 normal", 32'h4078_0000, 32'h3FD0_0000, 1'b0, 32'h40B0_0000);
    endtask

    // R12: four back-to-back operations, results in order at latency 4.
    task automatic t_stream;
        logic [31:0] a_v [4] = '{32'h3F80_0000, 32'h4078_0000,
                                 32'h3F80_0000, 32'h7F80_0000};
        logic [31:0] b_v [4] = '{32'h4000_0000, 32'h3FD0_0000,
                                 32'h3F40_0000, 32'h3F80_0000};
        logic        s_v [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
        logic [31:0] e_v [4] = '{32'h4040_0000, 32'h4010_0000,
                                 32'h3E80_0000, 32'h7F80_0000};
        for (int i = 0; i < 9; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                check("R12 valid", {31'b0, out_valid}, (i < 8) ? 32'd1 : 32'd0);
                if (i < 8) check("R12 order", result, e_v[i-4]);
            end else if (i >= 1) begin
                check("R12 early", {31'b0, out_valid}, 32'd0);
            end
            if (i < 4) begin
                op_a = a_v[i]; op_b = b_v[i]; sub_sel = s_v[i]; in_valid = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_sub();
        t_zero();
        t_round();
        t_special();
        t_overflow();
        t_subnormal();
        t_stream();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule